// File: doc/BRIEF.md
# Protection key access checker

This block keeps a per-thread rights register and checks each data access against it. A load/store unit sends a request with a strobe. The request carries a 4-bit key taken from spare page-entry bits, an access type, a privilege flag and a long-mode flag. One cycle later the block answers allow or deny, with a two-bit reason. Each of the 16 keys owns a pair of bits in the register: one blocks every access and one blocks only writes. Software changes what a key permits by writing the register through a dedicated write port, and never has to edit page tables to do so. A dedicated read port returns the current register value.

Instruction fetches are never checked. The same holds for supervisor accesses and for any access made outside 64-bit mode.

Top module: `pkey_checker`

## Requirements
- R1: After reset the rights register reads all zeros and no result is valid.
- R2: Key k's block-all bit is register bit 2k and its block-write bit is bit 2k+1. The read port always shows the register value.
- R3: A write strobe loads the register. The new value governs only checks issued on later cycles. A check issued in the same cycle as the write uses the old value.
- R4: Result valid rises exactly one cycle after a request strobe and is low in every other cycle.
- R5: A data read or write whose key has block-all set is denied with reason 2'b01 (access-disabled).
- R6: A data write whose key has only block-write set is denied with reason 2'b10 (write-disabled). A data read of that key is allowed.
- R7: Instruction fetches (access type 2'b10) are always allowed with reason 2'b00, whatever the key's rights.
- R8: Supervisor accesses (user flag 0) are always allowed with reason 2'b00.
- R9: Accesses with the long-mode flag at 0 are always allowed with reason 2'b00.
- R10: An allowed result always carries reason 2'b00, and a denied result never does. Access types: 2'b00 read, 2'b01 write, 2'b10 fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_key | input | 4 | Key index from the page entry |
| req_kind | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 for a user access, 0 for supervisor |
| req_long | input | 1 | 1 when the core is in 64-bit mode |
| rights_we | input | 1 | Write strobe for the rights register |
| rights_wdata | input | 32 | New rights value |
| rights_rdata | output | 32 | Current rights value |
| rsp_vld | output | 1 | Result valid, one cycle after the request |
| rsp_allow | output | 1 | 1 when the access is allowed |
| rsp_reason | output | 2 | 00 none, 01 access-disabled, 10 write-disabled |

## Verification
The bench sets the rights of the highest and lowest keys to each of their bit combinations. It then issues reads, writes and fetches against those keys. A checker that swapped the pair order, or indexed by key without doubling, would deny the wrong key or give the wrong reason. The bench also writes the register in the same cycle as a check. A design that bypassed the new value into that check would answer with the new rights one cycle early. The bench also runs supervisor, non-64-bit-mode and fetch requests against fully blocked keys. A design missing any of these exemptions would report denials there.

// File: rtl/pkey_pkg.sv
// Package: shared types and widths for the protection key checker.
package pkey_pkg;
    localparam int KEY_W   = 4;
    localparam int NUM_KEY = 1 << KEY_W;
    localparam int RIGHTS_W = 2 * NUM_KEY;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_kind_e;

    typedef enum logic [1:0] {
        RSN_NONE  = 2'b00,
        RSN_ALL   = 2'b01,
        RSN_WRITE = 2'b10
    } reason_e;
endpackage

// File: rtl/pkey_rights_reg.sv
// Module: rights register. It holds the per-key block-all/block-write bit pairs.
// Assumes: a single write port, with the new value visible on the next cycle.
module pkey_rights_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Register update: clear on reset, load on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/pkey_decide.sv
// Module: combinational decision for a single access.
// Assumes: the rights vector packs key k's block-all bit at 2k and its block-write bit at 2k+1.
module pkey_decide
    import pkey_pkg::*;
#(
    parameter int KW = KEY_W
) (
    input  logic [2*(1<<KW)-1:0] rights,
    input  logic [KW-1:0]        key,
    input  logic [1:0]           kind,
    input  logic                 user,
    input  logic                 long_mode,
    output logic                 allow,
    output logic [1:0]           reason
);
    localparam int NK = 1 << KW;

    logic [NK-1:0] ad_vec, wd_vec;

    // Split the packed register into per-key bit vectors.
    for (genvar k = 0; k < NK; k++) begin : g_split
        assign ad_vec[k] = rights[2*k];
        assign wd_vec[k] = rights[2*k+1];
    end

    logic checked;
    // Select the key's rights and choose the outcome.
    always_comb begin
        checked = long_mode && user && (kind != ACC_FETCH);
        allow   = 1'b1;
        reason  = RSN_NONE;
        if (checked) begin
            if (ad_vec[key]) begin
                allow  = 1'b0;
                reason = RSN_ALL;
            end else if (wd_vec[key] && kind == ACC_WRITE) begin
                allow  = 1'b0;
                reason = RSN_WRITE;
            end
        end
    end

    // R10
    reason_match_chk: assert final (allow == (reason == RSN_NONE));
endmodule

// File: rtl/pkey_checker.sv
// Module: protection key access checker (top). Gives a registered allow/deny one cycle after each request.
// Assumes: requests use the register value from before any write made in the same cycle.
module pkey_checker
    import pkey_pkg::*;
#(
    parameter int KW = KEY_W,
    localparam int RW = 2 * (1 << KW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld,
    input  logic [KW-1:0] req_key,
    input  logic [1:0]    req_kind,
    input  logic          req_user,
    input  logic          req_long,
    input  logic          rights_we,
    input  logic [RW-1:0] rights_wdata,
    output logic [RW-1:0] rights_rdata,
    output logic          rsp_vld,
    output logic          rsp_allow,
    output logic [1:0]    rsp_reason
);
    logic       d_allow;
    logic [1:0] d_reason;

    pkey_rights_reg #(.WIDTH(RW)) u_rights (
        .clk(clk), .rst_n(rst_n), .we(rights_we), .wdata(rights_wdata), .q(rights_rdata)
    );

    pkey_decide #(.KW(KW)) u_decide (
        .rights(rights_rdata), .key(req_key), .kind(req_kind), .user(req_user),
        .long_mode(req_long), .allow(d_allow), .reason(d_reason)
    );

    // Result stage: register the decision along with its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld    <= 1'b0;
            rsp_allow  <= 1'b1;
            rsp_reason <= RSN_NONE;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                rsp_allow  <= d_allow;
                rsp_reason <= d_reason;
            end
        end
    end

    // R4
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld == $past(req_vld));
    // R7
    fetch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == ACC_FETCH) |=> (rsp_allow && rsp_reason == RSN_NONE));
    // R8
    super_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_user) |=> rsp_allow);
    // R9
    legacy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_long) |=> rsp_allow);
    // R10
    rsp_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_allow == (rsp_reason == RSN_NONE)));
endmodule

// File: tb/pkey_checker_tb.sv
module pkey_checker_tb;
    logic clk = 0, rst_n = 0;
    logic req_vld = 0, req_user = 0, req_long = 0, rights_we = 0;
    logic [3:0] req_key = 0;
    logic [1:0] req_kind = 0;
    logic [31:0] rights_wdata = 0, rights_rdata;
    logic rsp_vld, rsp_allow;
    logic [1:0] rsp_reason;
    int errs = 0, checks = 0;
    logic [31:0] model = 0;
    logic [2:0] expq[$];
    string tagq[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    pkey_checker u_dut (.*);

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // The driver computes the expected result from the bench's own copy of the register.
    task automatic req(logic [3:0] k, logic [1:0] kind, bit u, bit l, string tag,
                       bit wr = 0, logic [31:0] wd = 0);
        logic [2:0] e;
        e = {1'b1, 2'b00};
        if (l && u && kind != 2'b10) begin
            if (model[2*k]) e = {1'b0, 2'b01};
            else if (model[2*k+1] && kind == 2'b01) e = {1'b0, 2'b10};
        end
        req_vld = 1; req_key = k; req_kind = kind; req_user = u; req_long = l;
        rights_we = wr; rights_wdata = wd;
        expq.push_back(e); tagq.push_back(tag);
        @(posedge clk); #1;
        if (wr) model = wd;
        req_vld = 0; rights_we = 0;
    endtask

    task automatic wr_rights(logic [31:0] v);
        rights_we = 1; rights_wdata = v;
        @(posedge clk); #1;
        rights_we = 0; model = v;
        chk(rights_rdata == v, "R2", rights_rdata, v);
    endtask

    // Monitor: on each negative edge, check the valid strobe and pop/compare a result.
    bit pend = 0;
    always @(negedge clk) if (rst_n && !done) begin
        if (pend) begin
            logic [2:0] e; string t;
            e = expq.pop_front(); t = tagq.pop_front();
            chk(rsp_vld, "R4", {31'b0, rsp_vld}, 1);
            chk({rsp_allow, rsp_reason} == e, t, {rsp_allow, rsp_reason}, e);
        end else if (rsp_vld) chk(0, "R4", 1, 0);
        pend = req_vld;
    end

    initial begin
        fork begin
            repeat (5000) @(posedge clk);
            chk(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end join_none
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        chk(rights_rdata == 0 && !rsp_vld, "R1", rights_rdata, 0);
        req(4'd3, 2'b01, 1, 1, "R1");
        wr_rights(32'h8000_0001);
        req(4'd0, 2'b00, 1, 1, "R5");
        req(4'd0, 2'b01, 1, 1, "R5");
        req(4'd15, 2'b00, 1, 1, "R6");
        req(4'd15, 2'b01, 1, 1, "R6");
        req(4'd1, 2'b01, 1, 1, "R2");
        req(4'd0, 2'b10, 1, 1, "R7");
        req(4'd0, 2'b01, 0, 1, "R8");
        req(4'd0, 2'b00, 1, 0, "R9");
        wr_rights(32'h4000_0002);
        req(4'd15, 2'b00, 1, 1, "R2");
        req(4'd1, 2'b01, 1, 1, "R6");
        req(4'd0, 2'b01, 1, 1, "R10");
        req(4'd15, 2'b01, 1, 1, "R3", 1, 32'h0);
        req(4'd15, 2'b01, 1, 1, "R3");
        req(4'd15, 2'b10, 1, 1, "R7");
        @(posedge clk); @(posedge clk); #1;
        done = 1;
        chk(expq.size() == 0, "R4", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule